// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software in a power-management controller. A down counter, clocked by a slow tick-enable input at 8 Hz, is loaded with a programmable period of 2^code ticks. That is 0.125 s for code 0, doubling at each step up to 4 s. Either polarity of transition on an asynchronous heartbeat input restarts the count. A host write strobe to the control register also restarts it, whether or not the write is accepted.

A two-bit mode picks the reaction to expiry:
- no reaction;
- a one-cycle timeout interrupt;
- a one-cycle wake interrupt together with a held reset request;
- an escalating sequence, with the timeout interrupt on the first expiry and the wake interrupt plus reset request on the second.

Mode and period are updated only while a key-open input is high. The stored values are shown on read-back outputs so that accepted and rejected writes can be seen.

When the controller is in its low-power state, a follow bit decides the watchdog's behaviour. With the bit clear, the watchdog is held off. With the bit set, it keeps to its programmed mode. The reset request stays high until an acknowledge arrives. While it is high, counting is frozen.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, cur_mode is 00, cur_tsel is 100, and irq_expire, irq_wake and rst_req are low.
- R2: A cfg_wr strobe with key_open low leaves cur_mode and cur_tsel unchanged. With key_open high, both take the written values on the next clock.
- R3: With mode 01 and period code c, irq_expire pulses on the 2^c-th tick_en after a restart and not before. Codes 110 and 111 count 32 ticks, the same as 101.
- R4: A rising or a falling transition on heartbeat_in restarts the count at the full period. The input passes through two synchronising flops and an edge detector, so the restart lands three clocks after the change.
- R5: Any cfg_wr strobe restarts the count, including a write rejected because key_open is low.
- R6: Mode 00 produces no interrupt and no reset request. Mode 01 produces irq_expire on every expiry and never irq_wake or rst_req.
- R7: Mode 10 produces irq_wake and sets rst_req on every expiry, and never irq_expire.
- R8: In mode 11, the first expiry gives irq_expire only. The next expiry gives irq_wake and rst_req. Any restart, or the watchdog being inactive, returns the sequence to its first stage.
- R9: irq_expire and irq_wake are single-cycle pulses. Each appears on the clock edge that samples the expiring tick.
- R10: rst_req stays high until rst_ack is high at a clock edge. While rst_req is high, the counter is frozen and no interrupt fires. The acknowledge restarts the count at the full period.
- R11: With lowpwr high and lowpwr_follow low, the watchdog is inactive: nothing fires, and the counter is held at the full period. With lowpwr_follow high, the programmed mode applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 8 Hz, the time base |
| heartbeat_in | input | 1 | Asynchronous heartbeat; either edge restarts the count |
| cfg_wr | input | 1 | Host write strobe to the control register |
| cfg_mode | input | 2 | Mode value carried by the write |
| cfg_tsel | input | 3 | Period code carried by the write |
| key_open | input | 1 | High when the security key is unlocked |
| lowpwr | input | 1 | Low-power state flag |
| lowpwr_follow | input | 1 | 1: obey the mode in low-power state; 0: held off |
| rst_ack | input | 1 | Acknowledge that clears rst_req |
| irq_expire | output | 1 | Timeout interrupt pulse |
| irq_wake | output | 1 | Wake interrupt pulse, paired with the reset request |
| rst_req | output | 1 | Held system reset request |
| cur_mode | output | 2 | Stored mode |
| cur_tsel | output | 3 | Stored period code |

## Verification
The hardest state to reach from the ports is the second stage of escalation mode. The bench must expire once without any heartbeat or write in between, and only then does a second expiry bring the reset. The bench makes this cheap by programming the shortest useful period and sending ticks as isolated enables.

To show that a restart returns the sequence to stage one, the bench places a heartbeat transition between two expiries and checks that the timeout interrupt comes back instead of the reset. Rejected writes are judged through the read-back outputs and through the fact that they still restart the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int TSEL_W   = 3;
  localparam int MAX_CODE = 5;
  localparam int CNT_W    = MAX_CODE + 1;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_IRQ = 2'b01,
    MODE_RST = 2'b10,
    MODE_ESC = 2'b11
  } wdog_mode_e;

  localparam logic [TSEL_W-1:0] TSEL_RESET = 3'b100;

  // Code clamped to the largest legal step; reserved codes map to the top.
  function automatic logic [TSEL_W-1:0] clamp_code(input logic [TSEL_W-1:0] code);
    if (int'(code) > MAX_CODE) return TSEL_W'(MAX_CODE);
    return code;
  endfunction

  // Period in ticks: two to the power of the clamped code.
  function automatic logic [CNT_W-1:0] period_ticks(input logic [TSEL_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return one << clamp_code(code);
  endfunction

endpackage

// File: rtl/wdog_hb_sync.sv
module wdog_hb_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_async,
  output logic hb_edge
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   hb_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= hb_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], hb_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_prev <= 1'b0;
    else        hb_prev <= chain[SYNC_STAGES-1];
  end

  assign hb_edge = chain[SYNC_STAGES-1] ^ hb_prev;

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              key_open,
  input  logic [1:0]        wr_mode,
  input  logic [TSEL_W-1:0] wr_tsel,
  output wdog_mode_e        mode,
  output logic [TSEL_W-1:0] tsel,
  output logic [TSEL_W-1:0] tsel_next
);

  logic accept;

  assign accept    = wr & key_open;
  assign tsel_next = accept ? wr_tsel : tsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_OFF;
      tsel <= TSEL_RESET;
    end else if (accept) begin
      mode <= wdog_mode_e'(wr_mode);
      tsel <= wr_tsel;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             reload,
  input  logic             freeze,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic last_tick;

  assign last_tick = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
  assign expire    = active & ~reload & ~freeze & tick & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= period_ticks(TSEL_RESET);
    end else if (!active || reload) begin
      cnt <= load_val;
    end else if (!freeze && tick) begin
      cnt <= last_tick ? load_val : cnt - 1'b1;
    end
  end

endmodule

// File: rtl/wdog_escalate_ctl.sv
module wdog_escalate_ctl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wdog_mode_e mode,
  input  logic       expire,
  input  logic       restart,
  input  logic       ack,
  output logic       irq_expire,
  output logic       irq_wake,
  output logic       rst_req,
  output logic       first_seen
);

  logic fire_int;
  logic fire_rst;

  always_comb begin
    fire_int = 1'b0;
    fire_rst = 1'b0;
    if (expire) begin
      unique case (mode)
        MODE_IRQ: fire_int = 1'b1;
        MODE_RST: fire_rst = 1'b1;
        MODE_ESC: begin
          fire_int = ~first_seen;
          fire_rst = first_seen;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_expire <= 1'b0;
      irq_wake   <= 1'b0;
      rst_req    <= 1'b0;
      first_seen <= 1'b0;
    end else begin
      irq_expire <= fire_int;
      irq_wake   <= fire_rst;
      if (fire_rst)              rst_req <= 1'b1;
      else if (ack)              rst_req <= 1'b0;
      if (restart)               first_seen <= 1'b0;
      else if (expire && mode == MODE_ESC) first_seen <= ~first_seen;
    end
  end

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              heartbeat_in,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode,
  input  logic [TSEL_W-1:0] cfg_tsel,
  input  logic              key_open,
  input  logic              lowpwr,
  input  logic              lowpwr_follow,
  input  logic              rst_ack,
  output logic              irq_expire,
  output logic              irq_wake,
  output logic              rst_req,
  output logic [1:0]        cur_mode,
  output logic [TSEL_W-1:0] cur_tsel
);

  wdog_mode_e        mode;
  logic [TSEL_W-1:0] tsel_next;
  logic              hb_edge;
  logic              active;
  logic              ack_take;
  logic              reload;
  logic              expire;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  load_val;
  logic              first_seen;

  wdog_hb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .hb_async (heartbeat_in),
    .hb_edge  (hb_edge)
  );

  wdog_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .key_open  (key_open),
    .wr_mode   (cfg_mode),
    .wr_tsel   (cfg_tsel),
    .mode      (mode),
    .tsel      (cur_tsel),
    .tsel_next (tsel_next)
  );

  assign active   = (mode != MODE_OFF) & ~(lowpwr & ~lowpwr_follow);
  assign ack_take = rst_req & rst_ack;
  assign reload   = hb_edge | cfg_wr | ack_take;
  assign load_val = period_ticks(tsel_next);

  wdog_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .reload   (reload),
    .freeze   (rst_req),
    .tick     (tick_en),
    .load_val (load_val),
    .cnt      (cnt),
    .expire   (expire)
  );

  wdog_escalate_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .expire     (expire),
    .restart    (reload | ~active),
    .ack        (rst_ack),
    .irq_expire (irq_expire),
    .irq_wake   (irq_wake),
    .rst_req    (rst_req),
    .first_seen (first_seen)
  );

  assign cur_mode = mode;

endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              key_open,
  input logic              lowpwr,
  input logic              lowpwr_follow,
  input logic              rst_ack,
  input logic              irq_expire,
  input logic              irq_wake,
  input logic              rst_req,
  input logic [1:0]        cur_mode,
  input logic [TSEL_W-1:0] cur_tsel,
  input logic [CNT_W-1:0]  cnt,
  input logic              first_seen
);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_expire |=> !irq_expire);

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wake |=> !irq_wake);

  a_r10_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !rst_ack) |=> rst_req);

  a_r10_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!irq_expire && !irq_wake));

  a_r7_wake_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wake |-> rst_req);

  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00) |=> (!irq_expire && !irq_wake));

  a_r6_irq_mode_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01) |=> !irq_wake);

  a_r7_rst_mode_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b10) |=> !irq_expire);

  a_r2_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !key_open) |=> ($stable(cur_mode) && $stable(cur_tsel)));

  a_r11_lowpwr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && !lowpwr_follow) |=> (!irq_expire && !irq_wake && !first_seen));

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 1) && (int'(cnt) <= (1 << MAX_CODE)));

  a_r8_first_only_esc: assert property (@(posedge clk) disable iff (!rst_n)
    first_seen |-> (cur_mode == 2'b11));

endmodule

bind wdog_escalate wdog_escalate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .key_open      (key_open),
  .lowpwr        (lowpwr),
  .lowpwr_follow (lowpwr_follow),
  .rst_ack       (rst_ack),
  .irq_expire    (irq_expire),
  .irq_wake      (irq_wake),
  .rst_req       (rst_req),
  .cur_mode      (cur_mode),
  .cur_tsel      (cur_tsel),
  .cnt           (cnt),
  .first_seen    (first_seen)
);

// File: tb/wdog_escalate_tb.sv
`timescale 1ns/1ps
module wdog_escalate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       heartbeat_in = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [2:0] cfg_tsel = 3'b000;
  logic       key_open = 1'b0;
  logic       lowpwr = 1'b0;
  logic       lowpwr_follow = 1'b0;
  logic       rst_ack = 1'b0;
  logic       irq_expire, irq_wake, rst_req;
  logic [1:0] cur_mode;
  logic [2:0] cur_tsel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_escalate u_dut (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .heartbeat_in (heartbeat_in),
    .cfg_wr (cfg_wr), .cfg_mode (cfg_mode), .cfg_tsel (cfg_tsel), .key_open (key_open),
    .lowpwr (lowpwr), .lowpwr_follow (lowpwr_follow), .rst_ack (rst_ack),
    .irq_expire (irq_expire), .irq_wake (irq_wake), .rst_req (rst_req),
    .cur_mode (cur_mode), .cur_tsel (cur_tsel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected period from the requirement: 2^code, codes above 5 count 32.
  function automatic int exp_ticks(input int code);
    return (code > 5) ? 32 : (1 << code);
  endfunction

  task automatic host_write(input logic [1:0] m, input logic [2:0] t, input logic key);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m; cfg_tsel = t; key_open = key;
    @(negedge clk);
    cfg_wr = 1'b0; key_open = 1'b0;
  endtask

  task automatic one_tick(output logic ie, output logic iw);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    ie = irq_expire; iw = irq_wake;
  endtask

  task automatic run_ticks(input int n, output int ne, output int nw);
    logic ie, iw;
    ne = 0; nw = 0;
    for (int i = 0; i < n; i++) begin
      one_tick(ie, iw);
      ne += int'(ie); nw += int'(iw);
    end
  endtask

  task automatic hb_toggle();
    @(negedge clk); heartbeat_in = ~heartbeat_in;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_reset();
    @(negedge clk); rst_ack = 1'b1;
    @(negedge clk); rst_ack = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1", "cur_mode", cur_mode, 0);
    check("R1", "cur_tsel", cur_tsel, 4);
    check("R1", "irq_expire", irq_expire, 0);
    check("R1", "irq_wake", irq_wake, 0);
    check("R1", "rst_req", rst_req, 0);
  endtask

  task automatic t_locked_write();
    int ne, nw;
    host_write(2'b01, 3'b000, 1'b0);
    check("R2", "locked cur_mode", cur_mode, 0);
    check("R2", "locked cur_tsel", cur_tsel, 4);
    run_ticks(40, ne, nw);
    check("R6", "mode off irq count", ne + nw, 0);
    check("R6", "mode off rst_req", rst_req, 0);
  endtask

  task automatic t_periods();
    int ne, nw;
    logic ie, iw;
    int codes[4] = '{0, 2, 5, 6};
    foreach (codes[k]) begin
      host_write(2'b01, 3'(codes[k]), 1'b1);
      check("R2", "unlocked cur_mode", cur_mode, 1);
      check("R2", "unlocked cur_tsel", cur_tsel, codes[k]);
      run_ticks(exp_ticks(codes[k]) - 1, ne, nw);
      check("R3", $sformatf("early irq code %0d", codes[k]), ne, 0);
      one_tick(ie, iw);
      check("R3", $sformatf("expiry code %0d", codes[k]), ie, 1);
      check("R6", "irq mode wake", iw, 0);
      @(negedge clk);
      check("R9", "irq_expire single cycle", irq_expire, 0);
      check("R6", "irq mode rst_req", rst_req, 0);
    end
  endtask

  task automatic t_heartbeat();
    int ne, nw;
    logic ie, iw;
    host_write(2'b01, 3'b010, 1'b1);
    for (int j = 0; j < 2; j++) begin
      run_ticks(3, ne, nw);
      hb_toggle();
      run_ticks(3, ne, nw);
      check("R4", $sformatf("no expiry after hb edge %0d", j), ne, 0);
    end
    one_tick(ie, iw);
    check("R4", "expiry after hb restarts", ie, 1);
  endtask

  task automatic t_write_reload();
    int ne, nw;
    logic ie, iw;
    host_write(2'b01, 3'b010, 1'b1);
    run_ticks(3, ne, nw);
    host_write(2'b10, 3'b000, 1'b0);
    run_ticks(3, ne, nw);
    check("R5", "rejected write restarts count", ne + nw, 0);
    one_tick(ie, iw);
    check("R5", "expiry after write restart", ie, 1);
    check("R2", "rejected write kept mode", iw, 0);
  endtask

  task automatic t_reset_mode();
    int ne, nw;
    logic ie, iw;
    host_write(2'b10, 3'b001, 1'b1);
    run_ticks(1, ne, nw);
    one_tick(ie, iw);
    check("R7", "wake on expiry", iw, 1);
    check("R7", "no timeout irq", ie, 0);
    check("R7", "rst_req set", rst_req, 1);
    @(negedge clk);
    check("R9", "irq_wake single cycle", irq_wake, 0);
    run_ticks(6, ne, nw);
    check("R10", "frozen while held", ne + nw, 0);
    check("R10", "rst_req held", rst_req, 1);
    ack_reset();
    check("R10", "rst_req cleared by ack", rst_req, 0);
    run_ticks(1, ne, nw);
    check("R10", "full period after ack", ne + nw, 0);
    one_tick(ie, iw);
    check("R10", "expiry after ack restart", iw, 1);
    ack_reset();
  endtask

  task automatic t_escalate();
    int ne, nw;
    logic ie, iw;
    host_write(2'b11, 3'b001, 1'b1);
    run_ticks(2, ne, nw);
    check("R8", "first stage timeout irq", ne, 1);
    check("R8", "first stage no wake", nw, 0);
    check("R8", "first stage no rst_req", rst_req, 0);
    run_ticks(2, ne, nw);
    check("R8", "second stage wake", nw, 1);
    check("R8", "second stage no timeout irq", ne, 0);
    check("R8", "second stage rst_req", rst_req, 1);
    ack_reset();
    run_ticks(2, ne, nw);
    check("R8", "ack returns to first stage", ne, 1);
    hb_toggle();
    one_tick(ie, iw);
    one_tick(ie, iw);
    check("R8", "hb restart returns to first stage irq", ie, 1);
    check("R8", "hb restart returns to first stage wake", iw, 0);
    check("R8", "no rst_req after restart", rst_req, 0);
  endtask

  task automatic t_lowpwr();
    int ne, nw;
    logic ie, iw;
    host_write(2'b01, 3'b001, 1'b1);
    @(negedge clk); lowpwr = 1'b1; lowpwr_follow = 1'b0;
    run_ticks(10, ne, nw);
    check("R11", "held off in low power", ne + nw, 0);
    @(negedge clk); lowpwr_follow = 1'b1;
    one_tick(ie, iw);
    check("R11", "full period after gate", ie, 0);
    one_tick(ie, iw);
    check("R11", "follows mode in low power", ie, 1);
    @(negedge clk); lowpwr = 1'b0; lowpwr_follow = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_locked_write();
    t_periods();
    t_heartbeat();
    t_write_reload();
    t_reset_mode();
    t_escalate();
    t_lowpwr();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule